// File: doc/BRIEF.md
# Cross-Domain Command Bridge

This block moves one bus command at a time from a source clock domain into a destination clock domain, and returns a completion back to the source. The source presents a packed command word with a one-cycle request strobe. The word holds a write flag, a read flag, a 17-bit address split into a 3-bit upper part and a 14-bit lower part, and 32 bits of write data. In the destination domain the bridge issues a single write strobe or a single read strobe on a plain user bus. It samples the read data there and returns a one-cycle acknowledge with a 32-bit return word on the source side.

A typical source is a narrow external bus front end that assembles the 32-bit write data from two 16-bit beats. The upper half is taken from the bus value present when the request is raised, and the lower half is the beat latched one cycle earlier. The bridge carries the whole word as it is and does not depend on how the source builds it. A request is crossed by flipping a toggle that passes through a synchronizer. The command word stays in a source-side register until the acknowledge returns. The acknowledge travels back on its own toggle and synchronizer. Only one command can be outstanding, and a request strobe raised while one is pending is dropped.

Top module: `xdom_cmd_bridge`

## Requirements
- R1: Command word layout, from the top bit down: bit 50 is the write flag, bit 49 is the read flag, bits 48:46 are the upper address part, bits 45:32 are the lower address part, and bits 31:0 are the write data. `dst_addr` equals bits 48:32 of the accepted command, with the upper part in address bits 16:14.
- R2: An accepted command with the write flag set raises `dst_wr_en` for exactly one destination cycle, with `dst_addr` and `dst_wdata` taken from the command. `dst_rd_en` stays low, even when the read flag is also set.
- R3: An accepted command with the read flag set and the write flag clear raises `dst_rd_en` for exactly one destination cycle at the command address. The write-data field is ignored and `dst_wr_en` stays low.
- R4: For a read, the bridge samples `dst_rdata` at the destination edge that ends the cycle after the `dst_rd_en` cycle, and returns that value on `src_rdata`.
- R5: Each accepted command yields exactly one `src_ack` pulse, one source cycle long. `src_rdata` holds the return word during that cycle and does not change until the next acknowledge.
- R6: A request strobe sampled after a command is accepted, up to and including the source edge that raises its `src_ack`, is ignored. It produces no destination strobe and no acknowledge.
- R7: A command with both flags clear produces no destination strobe but is still acknowledged.
- R8: While reset is asserted, `src_ack`, `dst_wr_en` and `dst_rd_en` are low.
- R9: R1 to R7 hold both when the destination clock is slower than the source clock and when it is faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain reset, active low, asynchronous |
| src_req | input | 1 | One-cycle request strobe |
| src_cmd | input | 51 | Packed command word (see R1) |
| src_ack | output | 1 | One-cycle completion pulse |
| src_rdata | output | 32 | Return word, valid with `src_ack` |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain reset, active low, asynchronous |
| dst_addr | output | 17 | User-bus address |
| dst_wr_en | output | 1 | One-cycle write strobe |
| dst_wdata | output | 32 | User-bus write data |
| dst_rd_en | output | 1 | One-cycle read strobe |
| dst_rdata | input | 32 | User-bus read data |

## Verification
The address sweep covers all eight upper-part values, each paired with the lowest, highest and two alternating-bit lower parts. Every address is written with a value derived from that address and then read back, so a swapped or shifted address field shows up as a mismatch. Reads of addresses never written return a computable initial pattern, which separates real reads from stale return data. The bench model drives valid read data only in the single destination cycle after the read strobe, so sampling one cycle early or late is caught. Commands with both flags set, with no flag set, and a second strobe issued while the first is pending exercise the decode priority and the drop rule. The whole sweep runs once with a slower destination clock and once with a faster one.

// File: rtl/xdb_pkg.sv
package xdb_pkg;

   // Destination-side operation decoded from the two command flags.
   typedef enum logic [1:0] {
      XDB_OP_IDLE  = 2'd0,
      XDB_OP_WRITE = 2'd1,
      XDB_OP_READ  = 2'd2
   } xdb_op_e;

   // The write flag outranks the read flag; no flag means a bare round trip.
   function automatic xdb_op_e xdb_decode(input logic wr_flag, input logic rd_flag);
      if (wr_flag)
         return XDB_OP_WRITE;
      else if (rd_flag)
         return XDB_OP_READ;
      return XDB_OP_IDLE;
   endfunction

endpackage

// File: rtl/xdb_sync.sv
module xdb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/xdb_src_side.sv
module xdb_src_side #(
   parameter int unsigned CMD_W  = 51,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic              ack_tgl_sync,
   input  logic [DATA_W-1:0] ret_word,
   output logic [CMD_W-1:0]  cmd_q,
   output logic              req_tgl,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic              busy
);

   logic ack_seen_q;
   logic ack_edge;

   assign ack_edge = ack_tgl_sync ^ ack_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= '0;
         req_tgl    <= 1'b0;
         ack_seen_q <= 1'b0;
         ack        <= 1'b0;
         rdata      <= '0;
         busy       <= 1'b0;
      end else begin
         ack_seen_q <= ack_tgl_sync;
         ack        <= ack_edge;
         if (ack_edge) begin
            // Return word crossed as a bus: it was settled before the toggle left.
            rdata <= ret_word;
            busy  <= 1'b0;
         end else if (req && !busy) begin
            cmd_q   <= cmd_in;
            req_tgl <= ~req_tgl;
            busy    <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/xdb_dst_side.sv
module xdb_dst_side
   import xdb_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CMD_W  = 51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_tgl_sync,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DATA_W-1:0] rdata_in,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wdata,
   output logic              rd_en,
   output logic              ack_tgl,
   output logic [DATA_W-1:0] ret_word
);

   localparam int unsigned WR_BIT  = CMD_W - 1;
   localparam int unsigned RD_BIT  = CMD_W - 2;
   localparam int unsigned ADDR_LSB = DATA_W;

   logic    req_seen_q;
   logic    req_edge;
   logic    issued_q;
   logic    wait_q;
   logic    rd_wait_q;
   xdb_op_e op;

   assign req_edge = req_tgl_sync ^ req_seen_q;
   assign op       = xdb_decode(cmd[WR_BIT], cmd[RD_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen_q <= 1'b0;
         issued_q   <= 1'b0;
         wait_q     <= 1'b0;
         rd_wait_q  <= 1'b0;
         wr_en      <= 1'b0;
         rd_en      <= 1'b0;
         addr       <= '0;
         wdata      <= '0;
         ack_tgl    <= 1'b0;
         ret_word   <= '0;
      end else begin
         req_seen_q <= req_tgl_sync;
         issued_q   <= req_edge;
         wait_q     <= issued_q;
         rd_wait_q  <= rd_en;
         wr_en      <= 1'b0;
         rd_en      <= 1'b0;
         if (req_edge) begin
            addr  <= cmd[ADDR_LSB +: ADDR_W];
            wdata <= cmd[DATA_W-1:0];
            wr_en <= (op == XDB_OP_WRITE);
            rd_en <= (op == XDB_OP_READ);
         end
         // Cycle after the strobe: user data is valid now, close the round trip.
         if (wait_q) begin
            ack_tgl <= ~ack_tgl;
            if (rd_wait_q)
               ret_word <= rdata_in;
         end
      end
   end

endmodule

// File: rtl/xdom_cmd_bridge.sv
module xdom_cmd_bridge #(
   parameter int unsigned ADDR_HI_W   = 3,
   parameter int unsigned ADDR_LO_W   = 14,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = ADDR_HI_W + ADDR_LO_W,
   localparam int unsigned CMD_W      = 2 + ADDR_W + DATA_W
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic              src_req,
   input  logic [CMD_W-1:0]  src_cmd,
   output logic              src_ack,
   output logic [DATA_W-1:0] src_rdata,
   input  logic              dst_clk,
   input  logic              dst_rst_n,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              dst_wr_en,
   output logic [DATA_W-1:0] dst_wdata,
   output logic              dst_rd_en,
   input  logic [DATA_W-1:0] dst_rdata
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("xdom_cmd_bridge: SYNC_STAGES must be at least 2");
      end
      if (ADDR_HI_W < 1 || ADDR_LO_W < 1) begin : g_bad_addr
         $error("xdom_cmd_bridge: both address parts need at least one bit");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xdom_cmd_bridge: DATA_W must be positive");
      end
   endgenerate

   logic [CMD_W-1:0]  cmd_held;
   logic              req_tgl;
   logic              req_tgl_dst;
   logic              ack_tgl;
   logic              ack_tgl_src;
   logic [DATA_W-1:0] ret_word;
   logic              src_busy;

   xdb_src_side #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_src (
      .clk         (src_clk),
      .rst_n       (src_rst_n),
      .req         (src_req),
      .cmd_in      (src_cmd),
      .ack_tgl_sync(ack_tgl_src),
      .ret_word    (ret_word),
      .cmd_q       (cmd_held),
      .req_tgl     (req_tgl),
      .ack         (src_ack),
      .rdata       (src_rdata),
      .busy        (src_busy)
   );

   xdb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk  (dst_clk),
      .rst_n(dst_rst_n),
      .d    (req_tgl),
      .q    (req_tgl_dst)
   );

   xdb_dst_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_dst (
      .clk         (dst_clk),
      .rst_n       (dst_rst_n),
      .req_tgl_sync(req_tgl_dst),
      .cmd         (cmd_held),
      .rdata_in    (dst_rdata),
      .addr        (dst_addr),
      .wr_en       (dst_wr_en),
      .wdata       (dst_wdata),
      .rd_en       (dst_rd_en),
      .ack_tgl     (ack_tgl),
      .ret_word    (ret_word)
   );

   xdb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk  (src_clk),
      .rst_n(src_rst_n),
      .d    (ack_tgl),
      .q    (ack_tgl_src)
   );

endmodule

// File: rtl/xdb_bridge_chk.sv
module xdb_bridge_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              src_clk,
   input logic              src_rst_n,
   input logic              dst_clk,
   input logic              dst_rst_n,
   input logic              src_ack,
   input logic [DATA_W-1:0] src_rdata,
   input logic              src_busy,
   input logic              dst_wr_en,
   input logic              dst_rd_en
);

   AST_WR_SINGLE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_wr_en |=> !dst_wr_en); // R2

   AST_RD_SINGLE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_rd_en |=> !dst_rd_en); // R3

   AST_WR_RD_EXCLUSIVE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      !(dst_wr_en && dst_rd_en)); // R2

   AST_ACK_SINGLE_CYCLE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      src_ack |=> !src_ack); // R5

   AST_RDATA_HELD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      !src_ack |-> $stable(src_rdata)); // R5

   AST_ACK_NEEDS_PENDING: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      src_ack |-> $past(src_busy)); // R6

endmodule

bind xdom_cmd_bridge xdb_bridge_chk #(.DATA_W(DATA_W)) u_chk (
   .src_clk  (src_clk),
   .src_rst_n(src_rst_n),
   .dst_clk  (dst_clk),
   .dst_rst_n(dst_rst_n),
   .src_ack  (src_ack),
   .src_rdata(src_rdata),
   .src_busy (src_busy),
   .dst_wr_en(dst_wr_en),
   .dst_rd_en(dst_rd_en)
);

// File: tb/tb_xdom_cmd_bridge.sv
`timescale 1ns/1ps
module tb_xdom_cmd_bridge;

   logic        src_clk = 1'b0;
   logic        dst_clk = 1'b0;
   logic        src_rst_n = 1'b0;
   logic        dst_rst_n = 1'b0;
   logic        src_req = 1'b0;
   logic [50:0] src_cmd = '0;
   logic        src_ack;
   logic [31:0] src_rdata;
   logic [16:0] dst_addr;
   logic        dst_wr_en;
   logic [31:0] dst_wdata;
   logic        dst_rd_en;
   logic [31:0] dst_rdata = 32'hBAD0_0000;

   real dst_half = 3.7;
   int  checks = 0;
   int  errors = 0;
   int  ack_cnt = 0;
   int  wr_cnt = 0;
   int  rd_cnt = 0;
   bit  finished = 1'b0;

   logic [16:0] last_wa;
   logic [31:0] last_wd;
   logic [16:0] rd_addr_s;
   logic        rd_prev = 1'b0;
   logic [31:0] dev_mem [logic [16:0]];
   logic [31:0] ref_mem [logic [16:0]];

   xdom_cmd_bridge dut (
      .src_clk  (src_clk),
      .src_rst_n(src_rst_n),
      .src_req  (src_req),
      .src_cmd  (src_cmd),
      .src_ack  (src_ack),
      .src_rdata(src_rdata),
      .dst_clk  (dst_clk),
      .dst_rst_n(dst_rst_n),
      .dst_addr (dst_addr),
      .dst_wr_en(dst_wr_en),
      .dst_wdata(dst_wdata),
      .dst_rd_en(dst_rd_en),
      .dst_rdata(dst_rdata)
   );

   initial forever #2.5 src_clk = ~src_clk;
   initial forever #(dst_half) dst_clk = ~dst_clk;

   function automatic logic [31:0] init_val(input logic [16:0] a);
      return 32'h9E3779B9 * {15'd0, a} + 32'h0000_1234;
   endfunction

   function automatic logic [31:0] ref_val(input logic [16:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
   endfunction

   // User-bus model: read data valid only in the cycle after the read strobe.
   initial forever begin
      @(negedge dst_clk);
      if (dst_wr_en === 1'b1) begin
         dev_mem[dst_addr] = dst_wdata;
         last_wa = dst_addr;
         last_wd = dst_wdata;
         wr_cnt++;
      end
      if (rd_prev)
         dst_rdata = dev_mem.exists(rd_addr_s) ? dev_mem[rd_addr_s] : init_val(rd_addr_s);
      else
         dst_rdata = 32'hBAD0_0000 ^ {15'd0, dst_addr};
      rd_prev = (dst_rd_en === 1'b1);
      if (dst_rd_en === 1'b1) begin
         rd_addr_s = dst_addr;
         rd_cnt++;
      end
   end

   initial forever begin
      @(negedge src_clk);
      if (src_ack === 1'b1) ack_cnt++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic send(input logic w, input logic r, input logic [16:0] a, input logic [31:0] d);
      @(negedge src_clk);
      src_req = 1'b1;
      src_cmd = {w, r, a, d};
      @(negedge src_clk);
      src_req = 1'b0;
   endtask

   task automatic wait_ack(output bit got);
      got = 1'b0;
      for (int n = 0; n < 300 && !got; n++) begin
         @(negedge src_clk);
         if (src_ack === 1'b1) got = 1'b1;
      end
   endtask

   // Write with optional read flag set too (R2 priority case).
   task automatic do_write(input logic [16:0] a, input logic [31:0] d, input logic also_rd);
      int a0 = ack_cnt, w0 = wr_cnt, r0 = rd_cnt;
      bit got;
      send(1'b1, also_rd, a, d);
      wait_ack(got);
      chk(got, "R5 write ack", {31'd0, got}, 32'd1);
      ref_mem[a] = d;
      repeat (10) @(negedge src_clk);
      chk(wr_cnt == w0 + 1, "R2 one write strobe", wr_cnt - w0, 1);
      chk(rd_cnt == r0, "R2 no read strobe", rd_cnt - r0, 0);
      chk(last_wa == a, "R1 address field", {15'd0, last_wa}, {15'd0, a});
      chk(last_wd == d, "R1 data field", last_wd, d);
      chk(ack_cnt == a0 + 1, "R5 one ack per write", ack_cnt - a0, 1);
   endtask

   task automatic do_read(input logic [16:0] a);
      int a0 = ack_cnt, w0 = wr_cnt, r0 = rd_cnt;
      logic [31:0] seen;
      bit got;
      send(1'b0, 1'b1, a, ~init_val(a));
      wait_ack(got);
      chk(got, "R5 read ack", {31'd0, got}, 32'd1);
      seen = src_rdata;
      chk(seen == ref_val(a), "R4 read data", seen, ref_val(a));
      repeat (10) @(negedge src_clk);
      chk(src_rdata == seen, "R5 return word held", src_rdata, seen);
      chk(rd_cnt == r0 + 1, "R3 one read strobe", rd_cnt - r0, 1);
      chk(wr_cnt == w0, "R3 no write strobe", wr_cnt - w0, 0);
      chk(ack_cnt == a0 + 1, "R5 one ack per read", ack_cnt - a0, 1);
   endtask

   task automatic run_phase(input int ph);
      logic [13:0] lows [4];
      int a0, w0, r0;
      bit got;
      lows[0] = 14'h0000; lows[1] = 14'h3FFF; lows[2] = 14'h2AAA; lows[3] = 14'h1555;
      // R9: same sweep under each clock ratio
      for (int hi = 0; hi < 8; hi++)
         for (int li = 0; li < 3; li++)
            do_write({hi[2:0], lows[li]}, init_val({hi[2:0], lows[li]}) ^ (32'hA5A5_0000 + ph), 1'b0);
      for (int hi = 0; hi < 8; hi++)
         for (int li = 0; li < 4; li++)
            do_read({hi[2:0], lows[li]});

      // R2: both flags set, write wins
      do_write(17'h1_0001, 32'h0BAD_F00D + ph, 1'b1);
      do_read(17'h1_0001);

      // R7: no flag, acknowledged without strobes
      a0 = ack_cnt; w0 = wr_cnt; r0 = rd_cnt;
      send(1'b0, 1'b0, 17'h0_0042, 32'hFFFF_FFFF);
      wait_ack(got);
      chk(got, "R7 ack without flags", {31'd0, got}, 32'd1);
      repeat (10) @(negedge src_clk);
      chk(wr_cnt == w0 && rd_cnt == r0, "R7 no strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
      chk(ack_cnt == a0 + 1, "R7 one ack", ack_cnt - a0, 1);

      // R6: second strobe while the first is pending is dropped
      a0 = ack_cnt; w0 = wr_cnt;
      @(negedge src_clk);
      src_req = 1'b1;
      src_cmd = {2'b10, 17'h0_0077, 32'h1111_0000 + ph};
      @(negedge src_clk);
      src_cmd = {2'b10, 17'h0_0078, 32'h2222_0000 + ph};
      @(negedge src_clk);
      src_req = 1'b0;
      ref_mem[17'h0_0077] = 32'h1111_0000 + ph;
      wait_ack(got);
      chk(got, "R6 first request acknowledged", {31'd0, got}, 32'd1);
      repeat (20) @(negedge src_clk);
      chk(wr_cnt == w0 + 1, "R6 dropped request made no strobe", wr_cnt - w0, 1);
      chk(ack_cnt == a0 + 1, "R6 dropped request made no ack", ack_cnt - a0, 1);
      do_read(17'h0_0078);
      do_read(17'h0_0077);
   endtask

   initial begin
      #30;
      chk(src_ack === 1'b0, "R8 src_ack in reset", {31'd0, src_ack}, 32'd0);
      chk(dst_wr_en === 1'b0, "R8 dst_wr_en in reset", {31'd0, dst_wr_en}, 32'd0);
      chk(dst_rd_en === 1'b0, "R8 dst_rd_en in reset", {31'd0, dst_rd_en}, 32'd0);
      #20;
      src_rst_n = 1'b1;
      dst_rst_n = 1'b1;
      repeat (5) @(negedge src_clk);

      dst_half = 3.7;   // destination slower
      run_phase(1);
      dst_half = 1.15;  // destination faster
      repeat (5) @(negedge src_clk);
      run_phase(2);
      summary();
   end

   initial begin
      #900000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0t expected=completion", $time);
      summary();
   end

endmodule